// File: doc/BRIEF.md
# Addressed Three-Wire Serial Frame Receiver

This block sits behind the host link of a segment display driver. The host uses three wires: chip enable, a serial clock and a data line. All three are brought into the system clock domain through a synchroniser and oversampled. Data is taken on each rising edge of the serial clock, as seen after synchronisation.

While chip enable is low, the block collects an 8-bit device address, least significant bit first. When chip enable rises, it records whether the last eight address bits equal the device address. It then collects a 40-bit payload while chip enable is high. When chip enable falls, a matched frame of exactly 40 bits is written to the holding registers. The last payload bit chooses what is written:
- A lower frame (direction 0) writes display bits 1 to 32 and the control fields.
- An upper frame (direction 1) writes display bits 33 to 64 only.

A panel with 32 segments or fewer can therefore be driven with lower frames alone. The serial clock may idle either low or high between transfers.

Top module: `serialFrameRx`

## Requirements
- R1: After reset, the display register, all control outputs, `loValid` and `hiValid` are zero.
- R2: An address byte is accepted only when the eight address bits sent during chip-enable-low are 1,1,1,1,0,0,1,0 in wire order (value 0x4F, least significant bit first). Any other address leaves every output unchanged.
- R3: A committed frame whose 40th payload bit is 0 is a lower frame. Payload bit k (k = 1..32, first bit sent is k = 1) goes to `dispBits[k-1]`. Bit 33 is padding. Bits 34, 35 and 36 go to `portMode[0]`, `portMode[1]` and `portMode[2]`. Bit 37 goes to `biasHalf`, bit 38 to `segOff` and bit 39 to `powerSave`.
- R4: A committed frame whose 40th payload bit is 1 is an upper frame. Payload bit k (k = 1..32) goes to `dispBits[31+k]`. The lower half and all control outputs keep their values.
- R5: A frame is committed only if exactly 40 payload bits were clocked in before chip enable fell. With 39 or 41 bits, every output is unchanged.
- R6: Frames are received identically whether the serial clock idles low or idles high between transfers.
- R7: `loValid` is set by the first committed lower frame, and `hiValid` by the first committed upper frame. Once set, each stays set until reset, and neither is set by anything else.
- R8: A commit appears on the outputs no later than four system clock cycles after chip enable is driven low. The display and control outputs change at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Chip enable from host (low: address phase, high: payload phase) |
| sclkIn | input | 1 | Serial clock from host |
| sdatIn | input | 1 | Serial data from host |
| dispBits | output | 64 | Display register; bit n-1 holds segment datum n |
| portMode | output | 3 | Output-port selection field from the lower frame |
| biasHalf | output | 1 | Bias-select control bit |
| segOff | output | 1 | Segment blanking control bit |
| powerSave | output | 1 | Power-saving control bit |
| loValid | output | 1 | A lower frame has been committed since reset |
| hiValid | output | 1 | An upper frame has been committed since reset |

## Verification
The hardest cases to reach are those where the commit qualifier must reject a frame that looks almost valid:
- a frame whose address is the correct byte sent in the wrong bit order;
- a frame one bit short or one bit long of 40;
- an upper frame arriving after a lower frame, which must leave the lower half and the control fields alone.

The stimulus reaches these with directed frames first, for both idle levels of the serial clock. It then mixes random payloads with an occasional wrong address or off-by-one length. After every frame, all outputs are compared against a bench model of the holding registers.

// File: rtl/serialFrameRxPkg.sv
package serialFrameRxPkg;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_PAY  = 1'b1
  } rxPhase_t;

  typedef struct packed {
    logic shiftAddr;
    logic shiftPay;
    logic payStart;
    logic frameEnd;
    logic commit;
  } rxStrb_t;

endpackage

// File: rtl/serialFrameRxSync.sv
module serialFrameRxSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/serialFrameRxCtrl.sv
module serialFrameRxCtrl
  import serialFrameRxPkg::*;
#(
  parameter int PAY_W = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceS,
  input  logic    sclkS,
  output rxStrb_t strb
);

  localparam int CNT_W = $clog2(PAY_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAY_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(PAY_W + 1);

  rxPhase_t phase;
  logic     sclkQ;
  logic     sclkRise;
  logic [CNT_W-1:0] bitCnt;

  assign sclkRise = sclkS && !sclkQ;

  always_comb begin
    strb           = '0;
    strb.payStart  = (phase == PH_ADDR) && ceS;
    strb.frameEnd  = (phase == PH_PAY) && !ceS;
    strb.shiftAddr = sclkRise && (phase == PH_ADDR) && !ceS;
    strb.shiftPay  = sclkRise && (phase == PH_PAY) && ceS;
    strb.commit    = strb.frameEnd && (bitCnt == CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_ADDR;
      sclkQ  <= 1'b0;
      bitCnt <= '0;
    end else begin
      sclkQ <= sclkS;
      phase <= ceS ? PH_PAY : PH_ADDR;
      if (strb.payStart)
        bitCnt <= '0;
      else if (strb.shiftPay && bitCnt != CNT_OVER)
        bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/serialFrameRxPath.sv
module serialFrameRxPath
  import serialFrameRxPkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  DEV_ADDR = 8'h4F,
  parameter int          HALF_W   = 32,
  parameter int          PAY_W    = 40,
  parameter int          CTRL_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrb_t             strb,
  input  logic                datS,
  output logic [2*HALF_W-1:0] dispReg,
  output logic [CTRL_W-1:0]   ctrlReg,
  output logic                loSeen,
  output logic                hiSeen
);

  localparam int DISP_W   = 2 * HALF_W;
  localparam int CTRL_LSB = HALF_W + 1;
  localparam int DIR_POS  = PAY_W - 1;

  logic [ADDR_W-1:0] addrSh;
  logic              matchQ;
  logic [PAY_W-1:0]  paySh;
  logic              dirBit;
  logic              unusedPad;

  assign dirBit    = paySh[DIR_POS];
  assign unusedPad = paySh[HALF_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSh <= '0;
      matchQ <= 1'b0;
      paySh  <= '0;
    end else begin
      if (strb.frameEnd)
        addrSh <= '0;
      else if (strb.shiftAddr)
        addrSh <= {datS, addrSh[ADDR_W-1:1]};
      if (strb.payStart)
        matchQ <= (addrSh == ADDR_W'(DEV_ADDR));
      if (strb.shiftPay)
        paySh <= {datS, paySh[PAY_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispReg <= '0;
      ctrlReg <= '0;
      loSeen  <= 1'b0;
      hiSeen  <= 1'b0;
    end else if (strb.commit && matchQ) begin
      if (dirBit) begin
        dispReg[DISP_W-1:HALF_W] <= paySh[HALF_W-1:0];
        hiSeen <= 1'b1;
      end else begin
        dispReg[HALF_W-1:0] <= paySh[HALF_W-1:0];
        ctrlReg <= paySh[CTRL_LSB +: CTRL_W];
        loSeen  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serialFrameRx.sv
module serialFrameRx
  import serialFrameRxPkg::*;
#(
  parameter int         HALF_W      = 32,
  parameter logic [7:0] DEV_ADDR    = 8'h4F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selIn,
  input  logic                sclkIn,
  input  logic                sdatIn,
  output logic [2*HALF_W-1:0] dispBits,
  output logic [2:0]          portMode,
  output logic                biasHalf,
  output logic                segOff,
  output logic                powerSave,
  output logic                loValid,
  output logic                hiValid
);

  localparam int ADDR_W = 8;
  localparam int CTRL_W = 6;
  localparam int PAY_W  = HALF_W + CTRL_W + 2;
  localparam int DISP_W = 2 * HALF_W;

  logic [2:0]        syncV;
  logic              ceS;
  logic              sclkS;
  logic              datS;
  rxStrb_t           strb;
  logic [CTRL_W-1:0] ctrlReg;

  serialFrameRxSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({selIn, sclkIn, sdatIn}),
    .syncOut(syncV)
  );

  assign {ceS, sclkS, datS} = syncV;

  serialFrameRxCtrl #(.PAY_W(PAY_W)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .ceS  (ceS),
    .sclkS(sclkS),
    .strb (strb)
  );

  serialFrameRxPath #(
    .ADDR_W  (ADDR_W),
    .DEV_ADDR(DEV_ADDR),
    .HALF_W  (HALF_W),
    .PAY_W   (PAY_W),
    .CTRL_W  (CTRL_W)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .datS   (datS),
    .dispReg(dispBits),
    .ctrlReg(ctrlReg),
    .loSeen (loValid),
    .hiSeen (hiValid)
  );

  assign portMode  = ctrlReg[2:0];
  assign biasHalf  = ctrlReg[3];
  assign segOff    = ctrlReg[4];
  assign powerSave = ctrlReg[5];

endmodule

// File: rtl/serialFrameRxChk.sv
module serialFrameRxChk
  import serialFrameRxPkg::*;
#(
  parameter int DISP_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input rxStrb_t           strb,
  input logic [DISP_W-1:0] dispBits,
  input logic [5:0]        ctrlBits,
  input logic              loValid,
  input logic              hiValid
);

  assert_disp_on_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dispBits) |-> $past(strb.commit));

  assert_ctrl_on_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlBits) |-> $past(strb.commit));

  assert_lo_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    loValid |=> loValid);

  assert_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    hiValid |=> hiValid);

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(loValid) || $rose(hiValid)) |-> $past(strb.commit));

  assert_commit_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit);

endmodule

bind serialFrameRx serialFrameRxChk #(.DISP_W(DISP_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .dispBits(dispBits),
  .ctrlBits({powerSave, segOff, biasHalf, portMode}),
  .loValid (loValid),
  .hiValid (hiValid)
);

// File: tb/sim_serialFrameRx.sv
module sim_serialFrameRx;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selIn = 1'b0;
  logic        sclkIn = 1'b0;
  logic        sdatIn = 1'b0;
  logic [63:0] dispBits;
  logic [2:0]  portMode;
  logic        biasHalf, segOff, powerSave, loValid, hiValid;

  int vectors = 0;
  int miscompares = 0;

  logic [63:0] expDisp = '0;
  logic [5:0]  expCtrl = '0;
  logic        expLo = 1'b0;
  logic        expHi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialFrameRx u0 (
    .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn), .sdatIn(sdatIn),
    .dispBits(dispBits), .portMode(portMode), .biasHalf(biasHalf),
    .segOff(segOff), .powerSave(powerSave), .loValid(loValid), .hiValid(hiValid)
  );

  function automatic bit accepted(input logic [7:0] addr, input int nBits);
    return (addr == 8'h4F) && (nBits == 40);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " display"}, dispBits, expDisp);
    check({tag, " control"}, 64'({powerSave, segOff, biasHalf, portMode}), 64'(expCtrl));
    check({tag, " R7 loValid"}, 64'(loValid), 64'(expLo));
    check({tag, " R7 hiValid"}, 64'(hiValid), 64'(expHi));
  endtask

  task automatic halfWait;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] addr, input logic [39:0] pay,
                           input int nBits, input bit idleHigh, input string tag);
    sclkIn = idleHigh;
    selIn  = 1'b0;
    halfWait();
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1'b0; sdatIn = addr[i]; halfWait();
      sclkIn = 1'b1; halfWait();
    end
    sclkIn = idleHigh; halfWait();
    selIn = 1'b1; halfWait();
    for (int i = 0; i < nBits; i++) begin
      sclkIn = 1'b0;
      sdatIn = (i < 40) ? pay[i] : 1'($urandom);
      halfWait();
      sclkIn = 1'b1; halfWait();
    end
    sclkIn = idleHigh; halfWait();
    selIn = 1'b0;
    if (accepted(addr, nBits)) begin
      if (pay[39]) begin
        expDisp[63:32] = pay[31:0];
        expHi = 1'b1;
      end else begin
        expDisp[31:0] = pay[31:0];
        expCtrl = pay[38:33];
        expLo = 1'b1;
      end
    end
    repeat (4) @(negedge clk);
    checkAll({tag, " R8"});
    halfWait();
  endtask

  function automatic logic [39:0] mkPay(input logic [31:0] d, input logic [5:0] c, input bit dir);
    return {dir, c, 1'b0, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkAll("R1 reset");

    // lower frame, clock idling low
    sendFrame(8'h4F, mkPay(32'hA5C3_0F81, 6'b101101, 1'b0), 40, 1'b0, "R3 lower idle-low R6");
    // upper frame, clock idling high; lower half and control must hold
    sendFrame(8'h4F, mkPay(32'h1234_FEDC, 6'b000000, 1'b1), 40, 1'b1, "R4 upper idle-high R6");
    // address mismatches
    sendFrame(8'h4E, mkPay(32'hFFFF_FFFF, 6'b111111, 1'b0), 40, 1'b0, "R2 wrong address");
    sendFrame(8'hF2, mkPay(32'h0000_0000, 6'b010101, 1'b1), 40, 1'b1, "R2 reversed bit order");
    // length errors
    sendFrame(8'h4F, mkPay(32'hDEAD_BEEF, 6'b110011, 1'b0), 39, 1'b0, "R5 short frame");
    sendFrame(8'h4F, mkPay(32'hCAFE_0001, 6'b001100, 1'b1), 41, 1'b1, "R5 long frame");
    // control all ones with clock idling high
    sendFrame(8'h4F, mkPay(32'h8000_0001, 6'b111111, 1'b0), 40, 1'b1, "R3 ctrl ones R6");

    for (int n = 0; n < 36; n++) begin
      logic [7:0] a;
      int len;
      a   = ($urandom % 5 == 0) ? 8'($urandom) : 8'h4F;
      len = ($urandom % 6 == 0) ? 38 + int'($urandom % 5) : 40;
      sendFrame(a, mkPay($urandom, 6'($urandom), 1'($urandom)), len, 1'($urandom),
                "R6 random R2 R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule